// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupt Detection

This block provides sixteen general-purpose I/O lines behind a simple 32-bit register interface. Each line can be an input or an output. When a line is an output, its pad driver is enabled and the pad takes the line's output data bit. Every pad value passes through a two-flop synchronizer, whatever the line's direction, and can be read back.

Each line has a 3-bit trigger code. The code selects one of five detection modes: high level, low level, rising edge, falling edge or any transition. When a line's mode is met, a sticky status bit is set, and that bit drives the line's own interrupt output toward the system interrupt controller. Software clears status bits by writing ones to them. A level condition that is still present sets its bit again at once, so a level interrupt only goes away once its source does.

A clock-output control register is also held here. It chooses whether the two top lines may carry a clock, but the clock generator itself lies outside the block, so the register is only stored and read back. Only aligned full-word accesses are decoded.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every line is an input (pad_oe all 0), pad_out is 0, all status bits and line_irq are 0, every trigger code is 0, and the direction register reads 0x0000FFFF.
- R2: Direction register (offset 0x04): bit n = 1 makes line n an input and bit n = 0 makes it an output. pad_oe[n] is the inverse of the direction bit, and pad_out[n] is bit n of the output data register (offset 0x00). Both registers read back what was written, in bits 15:0.
- R3: The input data register (offset 0x08) returns, in bits 15:0, the synchronized pad value of every line whatever its direction. A pad change is visible on a read taken after the second rising clock edge, and not after only the first.
- R4: The trigger code of line n is the 3-bit field at bit 3*(n mod 8), in the register at 0x10 for lines 0 to 7 and at 0x14 for lines 8 to 15. The codes are: 0 = level high, 1 = level low, 2 = rising edge, 3 = falling edge, 4 = either edge. A status bit sets at the third rising edge after the pad change. Both trigger registers read back their 24 stored bits.
- R5: Trigger codes 5, 6 and 7 never set a status bit.
- R6: The status register (offset 0x0C) holds one sticky bit per line. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. line_irq[n] equals status bit n.
- R7: For the level codes, a clear written while the level is still present leaves the bit set. A clear written after the level has gone removes it.
- R8: The clock-output control register (offset 0x18) stores all 32 bits and reads them back. Writing it changes neither pad_out nor pad_oe.
- R9: An access whose two low address bits are not zero is ignored on write and reads 0. Offset 0x1C and any unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for a full-word write |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables, 1 = drive |
| line_irq | output | 16 | Per-line interrupt requests |

## Verification
If a trigger code is decoded wrongly, or a field is mapped to the wrong line, the status word shows it on the very next read: a bit is missing, or set on the wrong line, three edges after a pad change. The bench sweeps every line against all eight codes through a low-high-low pad cycle, with a clear after each half. A wrong synchronizer depth shows up as a one-cycle shift in the input-data read. A wrong clear priority shows as a level bit that vanishes while its pad is still asserted.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register offsets and trigger encodings for the GPIO block.
// Assumes byte addressing with 32-bit aligned registers.
package gpio_irq_pkg;

    localparam int TRIG_W        = 3;
    localparam int LINES_PER_REG = 8;

    localparam logic [4:0] OFS_DOUT    = 5'h00;
    localparam logic [4:0] OFS_DIR     = 5'h04;
    localparam logic [4:0] OFS_DIN     = 5'h08;
    localparam logic [4:0] OFS_STAT    = 5'h0C;
    localparam logic [4:0] OFS_TRIG_LO = 5'h10;
    localparam logic [4:0] OFS_TRIG_HI = 5'h14;
    localparam logic [4:0] OFS_CLKO    = 5'h18;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_HIGH = 3'd0,
        TRIG_LOW  = 3'd1,
        TRIG_RISE = 3'd2,
        TRIG_FALL = 3'd3,
        TRIG_ANY  = 3'd4
    } trig_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer per line, plus one extra history stage for
// edge detection. Assumes pad_in is asynchronous to clk.
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);

    logic [W-1:0] meta_q;

    // Capture, resynchronize and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
            q_prev <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
            q_prev <= q;
        end
    end

endmodule

// File: rtl/gpio_line_detect.sv
// Module: trigger decode and sticky status bit for one line.
// Assumes lvl/lvl_prev are synchronous. A detected condition wins over a
// same-cycle clear, so level sources cannot be cleared while still present.
module gpio_line_detect
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic              lvl_prev,
    input  logic [TRIG_W-1:0] trig,
    input  logic              clr,
    output logic              status
);

    logic hit;

    // Decode the trigger code into this cycle's condition.
    always_comb begin
        case (trig)
            TRIG_HIGH: hit = lvl;
            TRIG_LOW:  hit = ~lvl;
            TRIG_RISE: hit = lvl & ~lvl_prev;
            TRIG_FALL: hit = ~lvl & lvl_prev;
            TRIG_ANY:  hit = lvl ^ lvl_prev;
            default:   hit = 1'b0;
        endcase
    end

    // Sticky status: set by the condition, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= 1'b0;
        else        status <= (status & ~clr) | hit;
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: GPIO controller top with register file, synchronizers, per-line
// detectors and pad enables. Assumes NLINES <= 16 (two trigger registers)
// and full-word aligned accesses only.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic [NLINES-1:0] line_irq
);

    localparam int TRIG_REG_BITS = TRIG_W * LINES_PER_REG;

    logic [NLINES-1:0]        dout_q;
    logic [NLINES-1:0]        dir_q;
    logic [DATA_W-1:0]        clko_q;
    logic [TRIG_W-1:0]        trig_q [NLINES];
    logic [NLINES-1:0]        sync_lvl;
    logic [NLINES-1:0]        sync_prev;
    logic [NLINES-1:0]        stat_clr;
    logic [TRIG_REG_BITS-1:0] trig_lo_v;
    logic [TRIG_REG_BITS-1:0] trig_hi_v;
    logic                     aligned;
    logic [5:0]               addr_full;

    assign aligned   = (reg_addr[1:0] == 2'b00);
    assign addr_full = 6'(reg_addr);

    // Flat registers: output data, direction and clock-output control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '1;
            clko_q <= '0;
        end else if (reg_wr && aligned) begin
            if (addr_full == 6'(OFS_DOUT)) dout_q <= reg_wdata[NLINES-1:0];
            if (addr_full == 6'(OFS_DIR))  dir_q  <= reg_wdata[NLINES-1:0];
            if (addr_full == 6'(OFS_CLKO)) clko_q <= reg_wdata;
        end
    end

    // Per-line trigger code storage, eight fields per register.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NLINES; i++) begin
            if (!rst_n) begin
                trig_q[i] <= '0;
            end else if (reg_wr && aligned &&
                         addr_full == 6'((i < LINES_PER_REG) ? OFS_TRIG_LO : OFS_TRIG_HI)) begin
                trig_q[i] <= reg_wdata[TRIG_W*(i % LINES_PER_REG) +: TRIG_W];
            end
        end
    end

    // Status clear strobes from a write of ones to the status register.
    assign stat_clr = (reg_wr && aligned && addr_full == 6'(OFS_STAT)) ?
                      reg_wdata[NLINES-1:0] : '0;

    gpio_in_sync #(.W(NLINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pad_in),
        .q      (sync_lvl),
        .q_prev (sync_prev)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        gpio_line_detect u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (sync_lvl[g]),
            .lvl_prev (sync_prev[g]),
            .trig     (trig_q[g]),
            .clr      (stat_clr[g]),
            .status   (line_irq[g])
        );
    end

    assign pad_out = dout_q;
    assign pad_oe  = ~dir_q;

    // Pack trigger codes into their two readback words.
    always_comb begin
        trig_lo_v = '0;
        trig_hi_v = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (i < LINES_PER_REG) trig_lo_v[TRIG_W*(i % LINES_PER_REG) +: TRIG_W] = trig_q[i];
            else                   trig_hi_v[TRIG_W*(i % LINES_PER_REG) +: TRIG_W] = trig_q[i];
        end
    end

    // Read mux; misaligned or unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            case (addr_full)
                6'(OFS_DOUT):    reg_rdata[NLINES-1:0]        = dout_q;
                6'(OFS_DIR):     reg_rdata[NLINES-1:0]        = dir_q;
                6'(OFS_DIN):     reg_rdata[NLINES-1:0]        = sync_lvl;
                6'(OFS_STAT):    reg_rdata[NLINES-1:0]        = line_irq;
                6'(OFS_TRIG_LO): reg_rdata[TRIG_REG_BITS-1:0] = trig_lo_v;
                6'(OFS_TRIG_HI): reg_rdata[TRIG_REG_BITS-1:0] = trig_hi_v;
                6'(OFS_CLKO):    reg_rdata                    = clko_q;
                default:         reg_rdata                    = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_chk.sv
// Module: protocol checker for gpio_irq_ctrl, attached by bind.
// Assumes the port names of the top module.
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NLINES-1:0] pad_out,
    input logic [NLINES-1:0] pad_oe,
    input logic [NLINES-1:0] line_irq
);

    // R1
    rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && line_irq == '0));

    // R2
    oe_from_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_DIR) |=> pad_oe == ~$past(reg_wdata[NLINES-1:0]));

    // R2
    out_from_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_DOUT) |=> pad_out == $past(reg_wdata[NLINES-1:0]));

    // R6
    stat_fall_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(line_irq) & ~line_irq)) |->
        ($past(reg_wr) && $past(reg_addr) == OFS_STAT &&
         ((($past(line_irq) & ~line_irq) & ~$past(reg_wdata[NLINES-1:0])) == '0)));

    // R8
    clko_no_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CLKO) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R9
    misaligned_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[1:0] != 2'b00) |-> reg_rdata == '0);

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(
    .NLINES(NLINES),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_gpio_irq_ctrl.sv
// Bench: sweeps every line through every trigger code with computed expectations.
module tb_gpio_irq_ctrl;

    localparam int CLK_P = 10;
    localparam int NL    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, line_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .line_irq(line_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_pad(input logic [15:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check_stat(input string req, input logic [15:0] exp);
        logic [31:0] d;
        rd(5'h0C, d);
        check(req, "status word", d, {16'h0, exp});
        check(req, "line_irq", {16'h0, line_irq}, {16'h0, exp});
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] lo, hi;
        logic [15:0] bitn, e;
        string rq;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "pad_oe", {16'h0, pad_oe}, 32'h0);
        check("R1", "pad_out", {16'h0, pad_out}, 32'h0);
        check("R1", "line_irq", {16'h0, line_irq}, 32'h0);
        rd(5'h04, d); check("R1", "direction", d, 32'h0000_FFFF);
        rd(5'h10, d); check("R1", "trig lo", d, 32'h0);
        rd(5'h14, d); check("R1", "trig hi", d, 32'h0);

        // R2 direction and output data patterns
        foreach (lo[k]) begin end
        for (int p = 0; p < 4; p++) begin
            logic [15:0] dv, ov;
            dv = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF : (p == 2) ? 16'hA5C3 : 16'h0F0F;
            ov = (p == 0) ? 16'h1234 : (p == 1) ? 16'hFFFF : (p == 2) ? 16'h5A5A : 16'h8001;
            wr(5'h04, {16'hDEAD, dv});
            wr(5'h00, {16'hBEEF, ov});
            check("R2", "pad_oe", {16'h0, pad_oe}, {16'h0, ~dv});
            check("R2", "pad_out", {16'h0, pad_out}, {16'h0, ov});
            rd(5'h04, d); check("R2", "dir readback", d, {16'h0, dv});
            rd(5'h00, d); check("R2", "dout readback", d, {16'h0, ov});
        end

        // R3 input data latency, with mixed direction
        wr(5'h04, 32'h0000_00FF);
        for (int p = 0; p < 3; p++) begin
            logic [15:0] pv, old;
            old = pad_in;
            pv = (p == 0) ? 16'hC3A5 : (p == 1) ? 16'h3C5A : 16'h0000;
            @(negedge clk); pad_in = pv;
            @(posedge clk);
            @(negedge clk); #1 reg_addr = 5'h08; #1
            check("R3", "din after one edge", reg_rdata, {16'h0, old});
            @(posedge clk);
            @(negedge clk); #1
            check("R3", "din after two edges", reg_rdata, {16'h0, pv});
        end
        wr(5'h04, 32'h0000_FFFF);

        // R4 trigger register readback
        wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); check("R4", "trig lo readback", d, 32'h00FF_FFFF);
        wr(5'h14, 32'h0012_3456); rd(5'h14, d); check("R4", "trig hi readback", d, 32'h0012_3456);

        // R4 R5 R6 R7 sweep: every line, every code, low-high-low pad cycle
        for (int n = 0; n < NL; n++) begin
            for (int c = 0; c < 8; c++) begin
                bitn = 16'(1) << n;
                lo = 0; hi = 0;
                for (int k = 0; k < 8; k++) begin
                    lo |= 32'((k == n) ? c : 5) << (3*k);
                    hi |= 32'((k + 8 == n) ? c : 5) << (3*k);
                end
                rq = (c >= 5) ? "R5" : "R4";
                set_pad(16'h0);
                wr(5'h10, lo);
                wr(5'h14, hi);
                wait_cyc(4);
                wr(5'h0C, 32'h0000_FFFF);
                e = (c == 1) ? bitn : 16'h0;
                check_stat(rq, e);
                set_pad(bitn);
                wait_cyc(4);
                if (c == 0 || c == 2 || c == 4) e |= bitn;
                check_stat(rq, e);
                if (c == 0) begin
                    wr(5'h0C, 32'h0);
                    check_stat("R6", e);
                end
                wr(5'h0C, 32'(bitn));
                e = (c == 0) ? bitn : 16'h0;
                check_stat("R7", e);
                set_pad(16'h0);
                wait_cyc(4);
                if (c == 1 || c == 3 || c == 4) e |= bitn;
                check_stat(rq, e);
                wr(5'h0C, 32'(bitn));
                e = (c == 1) ? bitn : 16'h0;
                check_stat("R7", e);
            end
        end

        // R8 clock-output register stored only
        wr(5'h04, 32'h0000_0F0F);
        wr(5'h00, 32'h0000_C001);
        wr(5'h18, 32'hA5A5_0003);
        rd(5'h18, d); check("R8", "clko readback", d, 32'hA5A5_0003);
        check("R8", "pad_out unchanged", {16'h0, pad_out}, 32'h0000_C001);
        check("R8", "pad_oe unchanged", {16'h0, pad_oe}, 32'h0000_F0F0);
        wr(5'h18, 32'h0);
        rd(5'h18, d); check("R8", "clko cleared", d, 32'h0);

        // R9 misaligned and unmapped accesses
        wr(5'h01, 32'h0000_FFFF);
        check("R9", "misaligned write ignored", {16'h0, pad_out}, 32'h0000_C001);
        wr(5'h06, 32'h0);
        check("R9", "misaligned dir write ignored", {16'h0, pad_oe}, 32'h0000_F0F0);
        rd(5'h01, d); check("R9", "misaligned read", d, 32'h0);
        rd(5'h1C, d); check("R9", "offset 0x1C read", d, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule